// File: doc/BRIEF.md
# Clock-Generator Watchdog with Safe-Frequency Fallback

This block watches over frequency reprogramming in a programmable clock generator. Once at least one of its two alarm enables is set, it measures a time-out. The time-out is a 3-bit multiplier times one of two base periods. A millisecond tick for this count is derived inside the block from a qualifying enable on the reference clock. System software services the watchdog with a service pulse, or by writing a new frequency-select code. If neither reaches the block before the time-out ends, an expiry occurs.

Each expiry pulses an alarm output for one cycle. If the soft enable is set, the expiry also sets the soft status bit. If the hard enable is set, the expiry sets the hard status bit and also takes over the frequency-select code seen by the synthesizer. That code is replaced by a safe code, taken either from the latched strap pins or from a 3-bit register field. The safe code uses the same 3-bit encoding as the normal select code. It stays in force until reset.

Top module: `clkgen_watchdog`

## Requirements
- R1: After reset, both status bits and `alarm_o` are 0, and `fsel_eff_o` equals `fsel_i`.
- R2: The count runs only while `hard_en_i` or `soft_en_i` is 1. While both are 0, no expiry occurs and the count is held at zero, so arming always starts a full time-out.
- R3: One millisecond is CLK_PER_MS cycles with `tick_en_i` high. The time-out is `mult_i` × BASE_SHORT_MS ms when `long_base_i`=0, and `mult_i` × BASE_LONG_MS ms when it is 1 (290 and 1160 by default). The expiry takes effect at the clock edge of the tick_en cycle that completes the time-out, and the outputs show it after that edge.
- R4: A pulse on `svc_i` or `fsel_wr_i` restarts the full time-out. If it lands in the cycle that would have expired, the restart wins and no expiry occurs.
- R5: Each expiry drives `alarm_o` high for exactly one cycle. An expiry with `soft_en_i`=1 sets `soft_stat_o`, which then holds.
- R6: An expiry with `hard_en_i`=1 sets `hard_stat_o` and forces `fsel_eff_o` to the safe code. The override stays until reset, even if `hard_en_i` is cleared or new codes are written.
- R7: `safe_src_i`=0 takes the safe code from `strap_fs_i`, and 1 takes it from `safe_code_i`. The code is captured at the first hard expiry, and later changes to either source have no effect. Without an override, `fsel_eff_o` follows `fsel_i`.
- R8: Clearing an enable clears its status bit at the next clock edge.
- R9: A multiplier of 0 disables expiry: no alarm occurs however long the count runs.
- R10: After an expiry the time-out restarts from zero, so an unserviced watchdog expires again once every full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Qualifies reference cycles counted toward a millisecond |
| svc_i | input | 1 | Service pulse, restarts the time-out |
| fsel_wr_i | input | 1 | Pulse marking a write of a new frequency code |
| fsel_i | input | 3 | Programmed frequency-select code |
| strap_fs_i | input | 3 | Frequency code latched from strap pins |
| hard_en_i | input | 1 | Hard alarm enable |
| soft_en_i | input | 1 | Soft alarm enable |
| long_base_i | input | 1 | Base period select: 0 short, 1 long |
| mult_i | input | 3 | Time-out multiplier |
| safe_src_i | input | 1 | Safe code source: 0 strap, 1 register |
| safe_code_i | input | 3 | Register safe code |
| hard_stat_o | output | 1 | Hard alarm status |
| soft_stat_o | output | 1 | Soft alarm status |
| alarm_o | output | 1 | One-cycle pulse per expiry |
| fsel_eff_o | output | 3 | Effective frequency-select code |

## Verification
The hardest case to reach is a restart that arrives in exactly the cycle that would expire. The bench arms the watchdog with the tick enable held high, so the expiry edge can be counted in advance. It then places a service pulse one negative edge before that edge and checks that the alarm appears one full period later. A second hard case is a captured safe code that must survive changes to its source, to `fsel_i` and to the enable. The bench changes all of these after a hard expiry and watches `fsel_eff_o` until the next reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Time-out in milliseconds for a multiplier and a base select.
  function automatic int unsigned timeout_ms(input logic [2:0] mult,
                                             input logic long_sel,
                                             input int unsigned base_short,
                                             input int unsigned base_long);
    int unsigned base;
    base = long_sel ? base_long : base_short;
    return int'(mult) * base;
  endfunction

  // Selects the source of the safe frequency code.
  function automatic logic [2:0] pick_safe(input logic from_reg,
                                           input logic [2:0] reg_code,
                                           input logic [2:0] strap_code);
    return from_reg ? reg_code : strap_code;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 14318,
  parameter int unsigned PW  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_en,
  output logic ms_tick
);
  logic [PW-1:0] cnt_q;
  logic          last;

  assign last    = (cnt_q == PW'(DIV - 1));
  assign ms_tick = tick_en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick_en) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ms_tick,
  input  logic [CW-1:0] limit_ms,
  output logic          expire
);
  logic [CW-1:0] elapsed_q;
  logic [CW:0]   next_ms;

  assign next_ms = {1'b0, elapsed_q} + 1'b1;
  assign expire  = ms_tick && !clr && (limit_ms != '0) &&
                   (next_ms >= {1'b0, limit_ms});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elapsed_q <= '0;
    else if (clr)     elapsed_q <= '0;
    else if (expire)  elapsed_q <= '0;
    else if (ms_tick) elapsed_q <= next_ms[CW-1:0];
  end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       hard_en,
  input  logic       soft_en,
  input  logic [2:0] safe_code,
  input  logic [2:0] fsel,
  output logic       hard_stat,
  output logic       soft_stat,
  output logic       alarm,
  output logic       locked,
  output logic [2:0] fsel_eff
);
  logic [2:0] safe_q;
  logic       take_over;

  assign take_over = expire && hard_en && !locked;
  assign fsel_eff  = locked ? safe_q : fsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_stat <= 1'b0;
      soft_stat <= 1'b0;
      alarm     <= 1'b0;
      locked    <= 1'b0;
      safe_q    <= '0;
    end else begin
      alarm     <= expire;
      hard_stat <= hard_en && (hard_stat || expire);
      soft_stat <= soft_en && (soft_stat || expire);
      if (take_over) begin
        locked <= 1'b1;
        safe_q <= safe_code;
      end
    end
  end
endmodule

// File: rtl/clkgen_watchdog.sv
module clkgen_watchdog #(
  parameter int unsigned CLK_PER_MS    = 14318,
  parameter int unsigned BASE_SHORT_MS = 290,
  parameter int unsigned BASE_LONG_MS  = 1160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en_i,
  input  logic       svc_i,
  input  logic       fsel_wr_i,
  input  logic [2:0] fsel_i,
  input  logic [2:0] strap_fs_i,
  input  logic       hard_en_i,
  input  logic       soft_en_i,
  input  logic       long_base_i,
  input  logic [2:0] mult_i,
  input  logic       safe_src_i,
  input  logic [2:0] safe_code_i,
  output logic       hard_stat_o,
  output logic       soft_stat_o,
  output logic       alarm_o,
  output logic [2:0] fsel_eff_o
);
  import wdt_pkg::*;

  localparam int unsigned MAX_BASE = (BASE_LONG_MS > BASE_SHORT_MS) ? BASE_LONG_MS : BASE_SHORT_MS;
  localparam int unsigned MAX_MS   = 7 * MAX_BASE;
  localparam int unsigned CW       = $clog2(MAX_MS + 1);
  localparam int unsigned PW       = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  // Named internal events, visible to the checker.
  logic          armed;
  logic          restart;
  logic          ms_tick;
  logic          expire;
  logic          locked;
  logic [CW-1:0] limit_ms;
  logic [2:0]    safe_code;

  assign armed     = hard_en_i || soft_en_i;
  assign restart   = svc_i || fsel_wr_i || !armed;
  assign limit_ms  = CW'(timeout_ms(mult_i, long_base_i, BASE_SHORT_MS, BASE_LONG_MS));
  assign safe_code = pick_safe(safe_src_i, safe_code_i, strap_fs_i);

  wdt_prescaler #(.DIV(CLK_PER_MS), .PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick_en(tick_en_i), .ms_tick(ms_tick)
  );

  wdt_timeout #(.CW(CW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(restart), .ms_tick(ms_tick),
    .limit_ms(limit_ms), .expire(expire)
  );

  wdt_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .expire(expire), .hard_en(hard_en_i),
    .soft_en(soft_en_i), .safe_code(safe_code), .fsel(fsel_i),
    .hard_stat(hard_stat_o), .soft_stat(soft_stat_o), .alarm(alarm_o),
    .locked(locked), .fsel_eff(fsel_eff_o)
  );
endmodule

// File: rtl/clkgen_watchdog_chk.sv
module clkgen_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       svc_i,
  input logic       fsel_wr_i,
  input logic       hard_en_i,
  input logic       soft_en_i,
  input logic       hard_stat_o,
  input logic       soft_stat_o,
  input logic       alarm_o,
  input logic       locked,
  input logic [2:0] fsel_eff_o
);
  assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hard_en_i && !soft_en_i) |=> !alarm_o);

  assert_restart_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_i || fsel_wr_i) |=> !alarm_o);

  assert_soft_rise_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_stat_o) |-> alarm_o);

  assert_hard_rise_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_stat_o) |-> (alarm_o && locked));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_safe_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(fsel_eff_o));

  assert_hard_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_en_i |=> !hard_stat_o);

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_en_i |=> !soft_stat_o);
endmodule

bind clkgen_watchdog clkgen_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .fsel_wr_i(fsel_wr_i),
  .hard_en_i(hard_en_i), .soft_en_i(soft_en_i), .hard_stat_o(hard_stat_o),
  .soft_stat_o(soft_stat_o), .alarm_o(alarm_o), .locked(locked),
  .fsel_eff_o(fsel_eff_o)
);

// File: tb/test_clkgen_watchdog.sv
module test_clkgen_watchdog;
  localparam int CPT = 3;
  localparam int BS  = 2;
  localparam int BL  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, svc = 1'b0, fwr = 1'b0;
  logic [2:0] fsel = 3'd0, strap = 3'd0, scode = 3'd0, mult = 3'd1;
  logic hen = 1'b0, sen = 1'b0, lbase = 1'b0, ssrc = 1'b0;
  logic hst, sst, alm;
  logic [2:0] feff;

  int n_chk = 0, n_fail = 0, cyc = 0, tick_mode = 0, tick_ctr = 0;
  int m_n = 0, m_lock = 0, m_safe = 0, m_hs = 0, m_ss = 0, m_alarm = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkgen_watchdog #(.CLK_PER_MS(CPT), .BASE_SHORT_MS(BS), .BASE_LONG_MS(BL)) i_clkgen_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .svc_i(svc), .fsel_wr_i(fwr),
    .fsel_i(fsel), .strap_fs_i(strap), .hard_en_i(hen), .soft_en_i(sen),
    .long_base_i(lbase), .mult_i(mult), .safe_src_i(ssrc), .safe_code_i(scode),
    .hard_stat_o(hst), .soft_stat_o(sst), .alarm_o(alm), .fsel_eff_o(feff)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model: counts qualified cycles since the last restart.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 0; m_lock = 0; m_safe = 0; m_hs = 0; m_ss = 0; m_alarm = 0;
    end else begin
      int lim;
      m_alarm = 0;
      lim = int'(mult) * (lbase ? BL : BS);
      if (svc || fwr || !(hen || sen)) m_n = 0;
      else if (tick_en) begin
        m_n++;
        if (lim != 0 && (m_n % CPT) == 0 && (m_n / CPT) >= lim) begin
          m_n = 0;
          m_alarm = 1;
          if (sen) m_ss = 1;
          if (hen) begin
            m_hs = 1;
            if (m_lock == 0) begin
              m_lock = 1;
              m_safe = ssrc ? int'(scode) : int'(strap);
            end
          end
        end
      end
      if (!hen) m_hs = 0;
      if (!sen) m_ss = 0;
    end
  end

  // Per-cycle comparison, away from both edges.
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      check("R5 alarm_o", int'(alm), m_alarm);
      check("R5 soft_stat_o", int'(sst), m_ss);
      check("R6 hard_stat_o", int'(hst), m_hs);
      check("R7 fsel_eff_o", int'(feff), m_lock ? m_safe : int'(fsel));
    end
  end

  // Tick enable pattern: always on, or one cycle in three.
  always @(negedge clk) begin
    tick_ctr++;
    tick_en <= (tick_mode == 0) ? 1'b1 : (tick_ctr % 3 == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // Counts sample points after arming until the first alarm.
  task automatic first_alarm(int maxc, output int at);
    at = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk); #3;
      if (alm && at < 0) at = i;
      if (at > 0) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
  endtask

  initial begin
    int at;
    idle(3); rst_n = 1'b1;
    @(negedge clk); #3;
    check("R1 hard_stat", int'(hst), 0);
    check("R1 soft_stat", int'(sst), 0);
    check("R1 alarm", int'(alm), 0);
    check("R1 fsel passthrough", int'(feff), 0);

    // R2: disarmed, nothing happens
    @(negedge clk); fsel = 3'd3; mult = 3'd1;
    first_alarm(80, at);
    check("R2 no alarm disarmed", at, -1);

    // R3: soft, short base, mult 1 -> 2 ms = 6 cycles
    @(negedge clk); sen = 1'b1;
    first_alarm(20, at);
    check("R3 short timeout", at, 6);
    check("R5 soft status set", int'(sst), 1);
    // R10: next expiry a full period later
    first_alarm(20, at);
    check("R10 repeat period", at, 6);

    // R8: clearing enable clears status
    @(negedge clk); sen = 1'b0;
    @(negedge clk); #3;
    check("R8 soft status cleared", int'(sst), 0);

    // R4: regular service keeps it quiet
    @(negedge clk); sen = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      svc = (i % 4 == 3); fwr = (i % 9 == 8);
    end
    @(negedge clk); svc = 1'b0; fwr = 1'b0; sen = 1'b0;
    check("R4 serviced no soft status", int'(sst), 0);

    // R4: restart on exactly the expiring cycle wins
    @(negedge clk); sen = 1'b1;
    at = -1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      svc = (i == 5);
      #3;
      if (alm && at < 0) at = i;
    end
    @(negedge clk); svc = 1'b0;
    check("R4 restart wins at expiry", at, 12);
    sen = 1'b0;

    // R3: long base, mult 2 -> 10 ms = 30 cycles
    @(negedge clk); lbase = 1'b1; mult = 3'd2;
    @(negedge clk); sen = 1'b1;
    first_alarm(40, at);
    check("R3 long timeout", at, 30);
    @(negedge clk); sen = 1'b0;

    // R9: multiplier zero never expires
    @(negedge clk); mult = 3'd0; lbase = 1'b0;
    @(negedge clk); sen = 1'b1;
    first_alarm(60, at);
    check("R9 mult zero no alarm", at, -1);
    @(negedge clk); sen = 1'b0; mult = 3'd1;

    // R6/R7: hard alarm with register safe code
    @(negedge clk); fsel = 3'd2; ssrc = 1'b1; scode = 3'd5;
    @(negedge clk); hen = 1'b1;
    first_alarm(20, at);
    check("R6 hard timeout", at, 6);
    check("R6 hard status", int'(hst), 1);
    check("R7 safe from register", int'(feff), 5);
    @(negedge clk); scode = 3'd3; fsel = 3'd6; fwr = 1'b1;
    @(negedge clk); fwr = 1'b0; hen = 1'b0;
    @(negedge clk); #3;
    check("R8 hard status cleared", int'(hst), 0);
    check("R6 override kept after disable", int'(feff), 5);

    // R7: strap source after reset
    do_reset();
    @(negedge clk); #3;
    check("R1 passthrough after reset", int'(feff), 6);
    @(negedge clk); ssrc = 1'b0; strap = 3'd4; scode = 3'd1; hen = 1'b1;
    first_alarm(20, at);
    check("R7 safe from strap", int'(feff), 4);
    @(negedge clk); strap = 3'd7;
    idle(3); #3;
    check("R7 strap change ignored", int'(feff), 4);

    // Sparse tick enable, both alarms, model compared every cycle
    @(negedge clk); hen = 1'b0; tick_mode = 1;
    @(negedge clk); sen = 1'b1; hen = 1'b1; mult = 3'd3;
    idle(150);
    @(negedge clk); sen = 1'b0; hen = 1'b0;
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule